// File: doc/BRIEF.md
# Sensor Core Soft Reset and Streaming Control

This block is the control-register front end of an image-sensor style datapath. A two-wire serial slave, which is not part of this block, turns bus transactions into single-cycle register writes and combinational reads on a simple address/data port. The block holds a streaming-enable bit, an interface configuration word and a core configuration byte. It also contains a small frame timing generator that gives frame-valid, line-valid and start-of-frame strobes together with a frame counter.

Writing a one to the soft-reset bit of the control word starts a fixed-length reset pulse to the core logic. That pulse clears the core configuration and the frame counter. It leaves the interface configuration and the streaming bit untouched. The frame in progress is dropped at once. When the pulse ends, the timing generator starts a fresh frame, provided streaming is enabled. The soft-reset bit is never stored, so it always reads back as zero. The active-low hard reset input clears everything, including the interface configuration.

Top module: `sctl_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the control word (address 0) reads 0x0000, the interface configuration (address 1) reads 0x0020, the core configuration (address 3) reads 0x0000, and `frame_cnt_o`, `core_rst_o`, `frame_valid_o`, `line_valid_o` and `frame_start_o` are all 0.
- R2: A write to address 0 with bit 0 set raises `core_rst_o` for exactly 4 clock cycles, starting in the cycle right after the write edge.
- R3: Bit 0 of the control word always reads 0, including while the reset pulse is active.
- R4: A soft reset does not change the interface configuration at address 1 or the streaming bit (bit 2 of address 0).
- R5: A soft reset clears the core configuration at address 3 and the frame counter (address 2 and `frame_cnt_o`) to 0.
- R6: A soft reset abandons the current frame. `frame_valid_o` and `line_valid_o` go low in the cycle after the write edge and stay low through the pulse. If streaming is enabled, `frame_start_o` rises 6 cycles after the write edge, which is 2 cycles after the last pulse cycle.
- R7: While bit 2 of address 0 is 0 (software standby), `frame_valid_o`, `line_valid_o` and `frame_start_o` stay 0, beginning 2 cycles after the write that clears the bit.
- R8: When streaming is enabled from standby, `frame_start_o` pulses 2 cycles after the write edge. Each frame lasts 70 cycles (7 lines of 10 cycles). `frame_valid_o` is high for the first 4 lines (40 cycles), and `line_valid_o` is high for the first 8 cycles of each of those lines (32 cycles). The frame counter increments one cycle after each start-of-frame.
- R9: A single write that sets both bit 0 and bit 2 starts no frame strobe until the reset pulse has ended. The first `frame_start_o` comes 6 cycles after the write edge.
- R10: Address 1 stores all 16 bits and address 3 stores the low 8 bits. Address 0 stores only bit 2. Address 2 is read-only. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hard reset of all logic |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| core_rst_o | output | 1 | Soft-reset pulse to core frame logic |
| frame_valid_o | output | 1 | Frame-valid strobe |
| line_valid_o | output | 1 | Line-valid strobe |
| frame_start_o | output | 1 | One-cycle start-of-frame strobe |
| frame_cnt_o | output | CNT_W | Frames started since the last reset |

## Verification
Plain register traffic is covered by a vector table. It includes full-width, truncated, read-only and unmapped writes, and it shows whether each field is stored at its own width or dropped. Streaming from standby is counted over a whole frame: the strobe totals and the frame counter step tell the correct line and frame geometry apart from off-by-one blanking. A soft reset is issued in three settings: in the middle of a streamed frame, from standby together with the streaming bit, and around configuration writes. Together these separate an abort from a missed abort, show a streaming start that correctly waits for the pulse, and tell core-only clearing apart from a reset that also wipes the interface configuration. A hard reset after the interface word has been changed confirms that only the hard reset restores its default.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  // control word bit positions
  localparam int SRST_BIT   = 0;
  localparam int STREAM_BIT = 2;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_IFCFG = 1;
  localparam int A_FCNT  = 2;
  localparam int A_CORE  = 3;

  // cycles per line including horizontal blanking
  function automatic int line_cycles(input int pix, input int hblank);
    return pix + hblank;
  endfunction

  // lines per frame including vertical blanking
  function automatic int frame_lines(input int lines, input int vblank);
    return lines + vblank;
  endfunction
endpackage

// File: rtl/sctl_rst_pulse.sv
module sctl_rst_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (trig)         remain <= CW'(PULSE_LEN);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign pulse_o = (remain != '0);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 16,
  parameter int          CORE_W    = 8,
  parameter int          CNT_W     = 16,
  parameter logic [15:0] IFCFG_RST = 16'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  frame_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              srst_req,
  output logic              stream_en,
  output logic [DATA_W-1:0] if_cfg
);
  logic [CORE_W-1:0] core_cfg;
  logic sel_ctrl, sel_if, sel_core;

  assign sel_ctrl = (addr == ADDR_W'(A_CTRL));
  assign sel_if   = (addr == ADDR_W'(A_IFCFG));
  assign sel_core = (addr == ADDR_W'(A_CORE));

  // soft reset request is a strobe; the bit itself is never stored
  assign srst_req = wr_en && sel_ctrl && wdata[SRST_BIT];

  // interface side: only the hard reset touches these
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_en <= 1'b0;
      if_cfg    <= DATA_W'(IFCFG_RST);
    end else if (wr_en) begin
      if (sel_ctrl) stream_en <= wdata[STREAM_BIT];
      if (sel_if)   if_cfg    <= wdata;
    end
  end

  // core side: cleared by the soft-reset pulse as well
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     core_cfg <= '0;
    else if (core_rst)              core_cfg <= '0;
    else if (wr_en && sel_core)     core_cfg <= wdata[CORE_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_CTRL):  rdata[STREAM_BIT] = stream_en;
      ADDR_W'(A_IFCFG): rdata = if_cfg;
      ADDR_W'(A_FCNT):  rdata = DATA_W'(frame_cnt);
      ADDR_W'(A_CORE):  rdata = DATA_W'(core_cfg);
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/sctl_frame_gen.sv
module sctl_frame_gen
  import sctl_pkg::*;
#(
  parameter int LINE_PIX = 8,
  parameter int HBLANK   = 2,
  parameter int LINES    = 4,
  parameter int VBLANK   = 3,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             stream_en,
  output logic             fv,
  output logic             lv,
  output logic             sof,
  output logic [CNT_W-1:0] frame_cnt
);
  localparam int LT = line_cycles(LINE_PIX, HBLANK);
  localparam int FT = frame_lines(LINES, VBLANK);
  localparam int HW = $clog2(LT);
  localparam int VW = $clog2(FT);

  logic          act;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;

  // run flag: dropped at once on hold, follows streaming otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= 1'b0;
    else if (hold) act <= 1'b0;
    else           act <= stream_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (hold || !act) begin
      hpos <= '0;
      vpos <= '0;
    end else if (hpos == HW'(LT - 1)) begin
      hpos <= '0;
      vpos <= (vpos == VW'(FT - 1)) ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign sof = act && (hpos == '0) && (vpos == '0);
  assign fv  = act && (vpos < VW'(LINES));
  assign lv  = fv && (hpos < HW'(LINE_PIX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame_cnt <= '0;
    else if (hold) frame_cnt <= '0;
    else if (sof)  frame_cnt <= frame_cnt + 1'b1;
  end
endmodule

// File: rtl/sctl_top.sv
module sctl_top #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4,
  parameter int LINE_PIX  = 8,
  parameter int HBLANK    = 2,
  parameter int LINES     = 4,
  parameter int VBLANK    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              core_rst_o,
  output logic              frame_valid_o,
  output logic              line_valid_o,
  output logic              frame_start_o,
  output logic [CNT_W-1:0]  frame_cnt_o
);
  // named internal events, visible to the bound checker
  logic              srst_req;
  logic              stream_en;
  logic              core_rst;
  logic              frame_hold;
  logic [DATA_W-1:0] if_cfg;

  sctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_W(8), .CNT_W(CNT_W),
    .IFCFG_RST(16'h0020)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frame_cnt(frame_cnt_o), .rdata(reg_rdata),
    .srst_req(srst_req), .stream_en(stream_en), .if_cfg(if_cfg)
  );

  sctl_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(srst_req), .pulse_o(core_rst)
  );

  // the frame generator drops its frame on the request edge and waits out the pulse
  assign frame_hold = srst_req || core_rst;

  sctl_frame_gen #(
    .LINE_PIX(LINE_PIX), .HBLANK(HBLANK), .LINES(LINES), .VBLANK(VBLANK),
    .CNT_W(CNT_W)
  ) u_fgen (
    .clk(clk), .rst_n(rst_n), .hold(frame_hold), .stream_en(stream_en),
    .fv(frame_valid_o), .lv(line_valid_o), .sof(frame_start_o),
    .frame_cnt(frame_cnt_o)
  );

  assign core_rst_o = core_rst;
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst,
  input logic              fv,
  input logic              lv,
  input logic              stream_en,
  input logic [DATA_W-1:0] if_cfg,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (core_rst) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  // R2: pulse never longer than PULSE_LEN
  a_r2_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (run_len < RW'(PULSE_LEN)));

  // R2: pulse is exactly PULSE_LEN when it ends
  a_r2_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (run_len == RW'(PULSE_LEN)));

  // R3: soft-reset bit never reads back set
  a_r3_srst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> !rdata[0]);

  // R4: interface configuration survives the pulse start
  a_r4_ifcfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $stable(if_cfg));

  // R6: no strobes while the core is in reset
  a_r6_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!fv && !lv));

  // R7: standby silences the frame-valid strobe from the next cycle
  a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> !fv);

  // R8: line-valid only inside frame-valid
  a_r8_lv_in_fv: assert property (@(posedge clk) disable iff (!rst_n)
    lv |-> fv);
endmodule

bind sctl_top sctl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
  .fv(frame_valid_o), .lv(line_valid_o), .stream_en(stream_en),
  .if_cfg(if_cfg), .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/sctl_top_tb.sv
`timescale 1ns/1ps
module sctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        core_rst_o, frame_valid_o, line_valid_o, frame_start_o;
  logic [15:0] frame_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst_o(core_rst_o),
    .frame_valid_o(frame_valid_o), .line_valid_o(line_valid_o),
    .frame_start_o(frame_start_o), .frame_cnt_o(frame_cnt_o)
  );

  // {addr, write data, expected read of the same address}
  localparam logic [35:0] VEC [0:5] = '{
    {4'd1, 16'hBEEF, 16'hBEEF},
    {4'd3, 16'h01A5, 16'h00A5},
    {4'd7, 16'h1234, 16'h0000},
    {4'd2, 16'hFFFF, 16'h0000},
    {4'd0, 16'hFFFE, 16'h0004},
    {4'd0, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // write on one edge; returns just after the following falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] rd(input logic [3:0] a);
    reg_addr = a;
    return 16'h0;
  endfunction

  task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #0.1;
    chk(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nfv, nlv, nsof;
    // R1: values during and after hard reset
    repeat (3) @(negedge clk);
    #1;
    rdchk("R1 ifcfg in reset", 4'd1, 16'h0020);
    rst_n = 1'b1;
    step();
    rdchk("R1 ctrl", 4'd0, 16'h0000);
    rdchk("R1 ifcfg", 4'd1, 16'h0020);
    rdchk("R1 core", 4'd3, 16'h0000);
    chk("R1 frame_cnt", {16'h0, frame_cnt_o}, 0);
    chk("R1 strobes", {28'h0, core_rst_o, frame_valid_o, line_valid_o, frame_start_o}, 0);

    // R7: standby after reset produces nothing
    nfv = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      nfv += int'(frame_valid_o) + int'(line_valid_o) + int'(frame_start_o);
    end
    chk("R7 standby idle", nfv, 0);

    // R10: register vector table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rdchk($sformatf("R10 vector %0d", i), VEC[i][35:32], VEC[i][15:0]);
    end

    // R1: hard reset restores interface default
    wr(4'd1, 16'h5555);
    hard_reset();
    rdchk("R1 ifcfg restored", 4'd1, 16'h0020);
    rdchk("R1 ctrl restored", 4'd0, 16'h0000);

    // R8: stream from standby, one full frame
    wr(4'd0, 16'h0004);
    chk("R8 no sof at N1", {31'h0, frame_start_o}, 0);
    step();
    nfv = 0; nlv = 0; nsof = 0;
    for (int i = 0; i < 70; i++) begin
      if (i > 0) step();
      nfv  += int'(frame_valid_o);
      nlv  += int'(line_valid_o);
      nsof += int'(frame_start_o);
    end
    chk("R8 fv cycles", nfv, 40);
    chk("R8 lv cycles", nlv, 32);
    chk("R8 sof per frame", nsof, 1);
    step();
    chk("R8 next sof", {31'h0, frame_start_o}, 1);
    chk("R8 count after one frame", {16'h0, frame_cnt_o}, 1);
    step();
    chk("R8 count after two", {16'h0, frame_cnt_o}, 2);

    // R7: back to standby
    wr(4'd0, 16'h0000);
    nfv = 0;
    for (int i = 0; i < 50; i++) begin
      step();
      nfv += int'(frame_valid_o) + int'(line_valid_o) + int'(frame_start_o);
    end
    chk("R7 standby after stream", nfv, 0);

    // R2 R3 R4 R5 R6: soft reset in mid-frame
    wr(4'd1, 16'h1234);
    wr(4'd3, 16'h0033);
    wr(4'd0, 16'h0004);
    repeat (16) step();
    chk("R6 mid-frame precondition", {31'h0, frame_valid_o}, 1);
    wr(4'd0, 16'h0005);
    for (int n = 1; n <= 4; n++) begin
      if (n > 1) step();
      chk($sformatf("R2 pulse N%0d", n), {31'h0, core_rst_o}, 1);
      chk($sformatf("R6 fv/lv low N%0d", n), {30'h0, frame_valid_o, line_valid_o}, 0);
      if (n == 2) rdchk("R3 bit0 during pulse", 4'd0, 16'h0004);
    end
    step();
    chk("R2 pulse ended N5", {31'h0, core_rst_o}, 0);
    chk("R6 no frame N5", {31'h0, frame_valid_o}, 0);
    step();
    chk("R6 new sof N6", {31'h0, frame_start_o}, 1);
    chk("R5 frame_cnt cleared", {16'h0, frame_cnt_o}, 0);
    rdchk("R3 R4 ctrl kept", 4'd0, 16'h0004);
    rdchk("R4 ifcfg kept", 4'd1, 16'h1234);
    rdchk("R5 core cleared", 4'd3, 16'h0000);
    step();
    chk("R5 count restarts", {16'h0, frame_cnt_o}, 1);

    // R9: combined soft reset and stream from standby
    wr(4'd0, 16'h0000);
    repeat (5) step();
    wr(4'd0, 16'h0005);
    nfv = 0;
    for (int n = 1; n <= 5; n++) begin
      if (n > 1) step();
      nfv += int'(frame_valid_o) + int'(frame_start_o);
    end
    chk("R9 no strobe during pulse", nfv, 0);
    step();
    chk("R9 sof after pulse", {31'h0, frame_start_o}, 1);
    rdchk("R9 stream bit set", 4'd0, 16'h0004);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule